// File: doc/BRIEF.md
# Forwarded-Clock Seven-Slot Lane Deserializer

This block rebuilds a wide parallel word from a small group of serial data lanes that travel next to a forwarded frame clock. Each lane carries seven bits per frame. The block runs on a sample clock at seven times the frame rate and gets one sample per bit slot from every lane and from the forwarded clock. The frame boundary is the slot in which the sampled forwarded clock goes from low to high. Once seven slots have been collected, the word goes to a parallel output. An output clock then rises one sample cycle later and marks the word as valid.

The block's outputs freeze in two cases. The first is when the active-low power-down input is held low. The second is when the forwarded clock stops toggling for longer than a programmable number of sample periods; the block then treats the clock as lost and drops alignment. On reset, on re-alignment after a lost clock, and on leaving power-down, the first complete frame is dropped so that the output clock only resumes on a settled word. The bit mapping is the exact inverse of a matching serializer, so a loopback returns each word unchanged.

Top module: `fwdclk_deser`

## Requirements
- R1: Output bit `l*7+s` is the value of lane `l` in slot `s` of a frame. Slot 0 is the sample in which `fwd_in` is 1 and the previous sample was 0, so a word serialized with that mapping comes back unchanged.
- R2: A frame is collected only once a forwarded-clock rise has been seen. If a new rise comes before seven slots have been collected, the partial frame is dropped and a new frame starts at that slot. This restart does not cause the following complete frame to be discarded.
- R3: The word from a complete frame appears on `word_out` at the clock edge after its seventh sample. `out_clk` rises one cycle later and stays high for HIGH_CYC (3) cycles before returning low.
- R4: After reset, `word_out` is all zeros and `out_clk` is low.
- R5: The first complete frame after reset, and the first after a forwarded-clock rise that follows lost alignment, is discarded. `out_clk` produces no rising edge for it.
- R6: While `pd_n` is 0, `word_out` and `out_clk` keep their values. The first frame that completes with `pd_n` at 1 after a power-down is discarded.
- R7: When the number of sample cycles since the last forwarded-clock rise reaches `stall_limit` (nonzero, at least 7), alignment is dropped. `out_clk` then stays low and `word_out` keeps the last word until frames resume.
- R8: A pause in the forwarded clock that is shorter than `stall_limit` keeps alignment, and the next complete frame is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one cycle per bit slot |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power-down, active low; freezes the outputs |
| fwd_in | input | 1 | Sampled forwarded frame clock |
| lane_in | input | N_LANES (4) | Sampled serial data lanes |
| stall_limit | input | STALL_W (8) | Sample cycles without a clock rise before the clock is treated as lost |
| word_out | output | N_LANES*N_SLOTS (28) | Rebuilt parallel word |
| out_clk | output | 1 | Output clock; its rising edge marks a new valid word |

## Verification
The loopback stream uses several word patterns: all ones, alternating halves, a walking one and pseudo-random words. These separate a correct lane and slot mapping from swapped lanes, reversed slot order or an off-by-one slot origin. A truncated frame shows whether an early clock rise restarts collection cleanly. Two pauses of different lengths tell a pause below `stall_limit` that must keep alignment from one above it that must drop it. A power-down window spanning several frames checks that the outputs freeze and that exactly one frame is dropped on wake-up. The width of each output clock pulse is also measured against HIGH_CYC.

// File: rtl/fwdclk_deser_pkg.sv
package fwdclk_deser_pkg;

   // Bits needed for a slot index that also has an idle code equal to n_slots
   function automatic int slot_bits(input int n_slots);
      return $clog2(n_slots + 1);
   endfunction

   typedef enum logic [1:0] {
      OUT_RUN  = 2'd0,
      OUT_SKIP = 2'd1
   } out_mode_e;

endpackage

// File: rtl/fwdclk_frame_track.sv
module fwdclk_frame_track #(
   parameter int N_SLOTS = 7,
   parameter int STALL_W = 8,
   parameter int SLOT_W  = fwdclk_deser_pkg::slot_bits(7)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fwd_in,
   input  logic [STALL_W-1:0] stall_limit,
   output logic [SLOT_W-1:0]  cur_slot,
   output logic               take,
   output logic               last,
   output logic               rise,
   output logic               fresh,
   output logic               stalled,
   output logic               aligned
);

   localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(N_SLOTS);
   localparam logic [SLOT_W-1:0] END_SLOT  = SLOT_W'(N_SLOTS - 1);

   logic               fwd_prev_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [STALL_W-1:0] since_q;
   logic               aligned_q;

   assign rise     = fwd_in & ~fwd_prev_q;
   assign cur_slot = rise ? '0 : slot_q;
   assign take     = rise | (aligned_q & (slot_q < IDLE_SLOT));
   assign last     = take & (cur_slot == END_SLOT);
   assign fresh    = rise & ~aligned_q;
   assign stalled  = (stall_limit != '0) && (since_q >= stall_limit);
   assign aligned  = aligned_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_prev_q <= 1'b0;
         slot_q     <= IDLE_SLOT;
         since_q    <= '0;
         aligned_q  <= 1'b0;
      end else begin
         fwd_prev_q <= fwd_in;
         if (take) begin
            slot_q <= cur_slot + SLOT_W'(1);
         end
         if (rise) begin
            since_q <= '0;
         end else if (since_q != '1) begin
            since_q <= since_q + STALL_W'(1);
         end
         if (rise) begin
            aligned_q <= 1'b1;
         end else if (stalled) begin
            aligned_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fwdclk_lane_gather.sv
module fwdclk_lane_gather #(
   parameter int N_LANES = 4,
   parameter int N_SLOTS = 7,
   parameter int SLOT_W  = fwdclk_deser_pkg::slot_bits(7),
   parameter int WORD_W  = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LANES-1:0] lane_in,
   input  logic [SLOT_W-1:0]  cur_slot,
   input  logic               take,
   input  logic               last,
   output logic [WORD_W-1:0]  frm_word,
   output logic               frm_vld
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_vld <= 1'b0;
      end else begin
         frm_vld <= last;
      end
   end

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      logic [N_SLOTS-2:0] acc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
         end else begin
            for (int s = 0; s < N_SLOTS - 1; s++) begin
               if (take && (cur_slot == SLOT_W'(s))) begin
                  acc_q[s] <= lane_in[l];
               end
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            frm_word[l*N_SLOTS +: N_SLOTS] <= '0;
         end else if (last) begin
            frm_word[l*N_SLOTS +: N_SLOTS] <= {lane_in[l], acc_q};
         end
      end
   end

endmodule

// File: rtl/fwdclk_out_stage.sv
module fwdclk_out_stage #(
   parameter int WORD_W   = 28,
   parameter int HIGH_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              frm_vld,
   input  logic [WORD_W-1:0] frm_word,
   input  logic              fresh,
   input  logic              stalled,
   output logic [WORD_W-1:0] word_out,
   output logic              out_clk
);

   import fwdclk_deser_pkg::*;

   out_mode_e   mode_q;
   logic        pend_q;
   logic [WORD_W-1:0] word_q;
   logic        accept;

   assign accept   = frm_vld & (mode_q == OUT_RUN);
   assign word_out = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= OUT_SKIP;
         pend_q <= 1'b0;
         word_q <= '0;
      end else if (!pd_n) begin
         mode_q <= OUT_SKIP;
      end else begin
         pend_q <= accept;
         if (accept) begin
            word_q <= frm_word;
         end
         if (fresh || stalled) begin
            mode_q <= OUT_SKIP;
         end else if (frm_vld) begin
            mode_q <= OUT_RUN;
         end
      end
   end

   if (HIGH_CYC == 1) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_clk <= 1'b0;
         end else if (pd_n) begin
            out_clk <= pend_q;
         end
      end
   end else begin : g_count
      localparam int HW = $clog2(HIGH_CYC);
      logic [HW-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_clk <= 1'b0;
            hold_q  <= '0;
         end else if (pd_n) begin
            if (pend_q) begin
               out_clk <= 1'b1;
               hold_q  <= HW'(HIGH_CYC - 1);
            end else if (hold_q != '0) begin
               hold_q  <= hold_q - HW'(1);
            end else begin
               out_clk <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/fwdclk_deser.sv
module fwdclk_deser #(
   parameter int N_LANES  = 4,
   parameter int N_SLOTS  = 7,
   parameter int STALL_W  = 8,
   parameter int HIGH_CYC = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pd_n,
   input  logic                         fwd_in,
   input  logic [N_LANES-1:0]           lane_in,
   input  logic [STALL_W-1:0]           stall_limit,
   output logic [N_LANES*N_SLOTS-1:0]   word_out,
   output logic                         out_clk
);

   localparam int WORD_W = N_LANES * N_SLOTS;
   localparam int SLOT_W = fwdclk_deser_pkg::slot_bits(N_SLOTS);

   if (N_LANES < 1) begin : g_bad_lanes
      $error("N_LANES must be at least 1");
   end
   if (N_SLOTS < 3) begin : g_bad_slots
      $error("N_SLOTS must be at least 3");
   end
   if (HIGH_CYC < 1 || HIGH_CYC > N_SLOTS - 2) begin : g_bad_high
      $error("HIGH_CYC must lie in 1..N_SLOTS-2");
   end
   if (STALL_W < $clog2(N_SLOTS + 1)) begin : g_bad_stall
      $error("STALL_W too narrow for a frame length");
   end

   logic [SLOT_W-1:0] cur_slot_w;
   logic              take_w, last_w, rise_w, fresh_w, stalled_w, aligned_w;
   logic [WORD_W-1:0] frm_word_w;
   logic              frm_vld_w;

   fwdclk_frame_track #(
      .N_SLOTS (N_SLOTS),
      .STALL_W (STALL_W),
      .SLOT_W  (SLOT_W)
   ) track_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fwd_in      (fwd_in),
      .stall_limit (stall_limit),
      .cur_slot    (cur_slot_w),
      .take        (take_w),
      .last        (last_w),
      .rise        (rise_w),
      .fresh       (fresh_w),
      .stalled     (stalled_w),
      .aligned     (aligned_w)
   );

   fwdclk_lane_gather #(
      .N_LANES (N_LANES),
      .N_SLOTS (N_SLOTS),
      .SLOT_W  (SLOT_W),
      .WORD_W  (WORD_W)
   ) gather_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_in  (lane_in),
      .cur_slot (cur_slot_w),
      .take     (take_w),
      .last     (last_w),
      .frm_word (frm_word_w),
      .frm_vld  (frm_vld_w)
   );

   fwdclk_out_stage #(
      .WORD_W   (WORD_W),
      .HIGH_CYC (HIGH_CYC)
   ) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd_n     (pd_n),
      .frm_vld  (frm_vld_w),
      .frm_word (frm_word_w),
      .fresh    (fresh_w),
      .stalled  (stalled_w),
      .word_out (word_out),
      .out_clk  (out_clk)
   );

endmodule

// File: rtl/fwdclk_deser_chk.sv
module fwdclk_deser_chk #(
   parameter int WORD_W = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pd_n,
   input logic [WORD_W-1:0] word_out,
   input logic              out_clk,
   input logic              stalled,
   input logic              rise,
   input logic              aligned,
   input logic              frm_vld
);

   // R6
   word_frozen_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pd_n) |-> $stable(word_out));

   // R6
   clk_frozen_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pd_n) |-> $stable(out_clk));

   // R3
   strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(word_out) && pd_n) |=> $rose(out_clk));

   // R7
   stall_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stalled && !rise) |-> !aligned);

   // R2
   frame_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |-> $past(aligned));

endmodule

bind fwdclk_deser fwdclk_deser_chk #(.WORD_W(WORD_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .pd_n     (pd_n),
   .word_out (word_out),
   .out_clk  (out_clk),
   .stalled  (stalled_w),
   .rise     (rise_w),
   .aligned  (aligned_w),
   .frm_vld  (frm_vld_w)
);

// File: tb/fwdclk_deser_tb_top.sv
module fwdclk_deser_tb_top;

   localparam int CLK_P = 10;
   localparam int NL    = 4;
   localparam int NS    = 7;
   localparam int WW    = NL * NS;
   localparam int HIGH  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pd_n = 1'b1;
   logic          fwd_in = 1'b0;
   logic [NL-1:0] lane_in = '0;
   logic [7:0]    stall_limit = 8'd20;
   logic [WW-1:0] word_out;
   logic          out_clk;

   int            n_chk = 0;
   int            n_fail = 0;
   logic [WW-1:0] exp_q[$];
   logic [WW-1:0] last_word = '0;
   logic [WW-1:0] head;
   bit            mon_on = 1'b0;
   bit            prev_clk = 1'b0;
   int            hi_w = 0;
   bit            done = 1'b0;

   fwdclk_deser dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pd_n        (pd_n),
      .fwd_in      (fwd_in),
      .lane_in     (lane_in),
      .stall_limit (stall_limit),
      .word_out    (word_out),
      .out_clk     (out_clk)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Driver: one frame, lane l slot s carries bit l*7+s (R1)
   task automatic send_frame(input logic [WW-1:0] w, input bit expect_out, input logic pd_val);
      for (int s = 0; s < NS; s++) begin
         @(negedge clk);
         fwd_in = (s < 4);
         for (int l = 0; l < NL; l++) lane_in[l] = w[l*NS + s];
         if (s == 5) pd_n = pd_val;
         if (s == 0 && expect_out) begin
            exp_q.push_back(w);
            last_word = w;
         end
      end
   endtask

   // R2: truncated frame, only four slots before the next rise
   task automatic short_frame();
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         fwd_in = (s < 2);
         lane_in = NL'($urandom);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fwd_in = 1'b0;
         lane_in = NL'($urandom);
      end
   endtask

   // Monitor: scoreboard pop on each output clock rise
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_clk && !prev_clk) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 strobe with no expected word", 32'(word_out), 32'(0));
            end else begin
               head = exp_q.pop_front();
               chk(word_out == head, "R1 rebuilt word", 32'(word_out), 32'(head));
            end
         end
         if (out_clk) begin
            hi_w++;
         end else if (prev_clk) begin
            chk(hi_w == HIGH, "R3 output clock high width", 32'(hi_w), 32'(HIGH));
            hi_w = 0;
         end
         prev_clk = out_clk;
      end
   end

   initial begin
      #(CLK_P * 200000);
      chk(1'b0, "watchdog expired", 32'(0), 32'(1));
      report();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4
      chk(word_out == '0, "R4 reset word", 32'(word_out), 32'(0));
      chk(out_clk == 1'b0, "R4 reset output clock", 32'(out_clk), 32'(0));
      mon_on = 1'b1;

      // R5: first frame after reset dropped; R1 patterns follow
      send_frame(28'h1234567, 1'b0, 1'b1);
      send_frame(28'hFFFFFFF, 1'b1, 1'b1);
      send_frame(28'hAAAAAAA, 1'b1, 1'b1);
      send_frame(28'h5555555, 1'b1, 1'b1);
      send_frame(28'h0000001, 1'b1, 1'b1);
      send_frame(28'h8000000, 1'b1, 1'b1);
      send_frame(28'h0003F80, 1'b1, 1'b1);
      for (int i = 0; i < 4; i++) send_frame(WW'($urandom), 1'b1, 1'b1);

      // R2: early rise restarts the frame, next one delivered
      short_frame();
      send_frame(28'h0F0F0F0, 1'b1, 1'b1);
      send_frame(28'hC3C3C3C, 1'b1, 1'b1);

      // R8: pause below the limit keeps alignment
      idle(10);
      send_frame(28'h2468ACE, 1'b1, 1'b1);
      send_frame(28'h7654321, 1'b1, 1'b1);

      // R6: power-down across frames, one frame dropped on wake
      send_frame(28'h1111111, 1'b0, 1'b0);
      send_frame(28'h2222222, 1'b0, 1'b0);
      send_frame(28'h3333333, 1'b0, 1'b0);
      chk(word_out == last_word, "R6 word held in power-down", 32'(word_out), 32'(last_word));
      chk(out_clk == 1'b0, "R6 output clock held in power-down", 32'(out_clk), 32'(0));
      send_frame(28'h4444444, 1'b0, 1'b1);
      send_frame(28'h5A5A5A5, 1'b1, 1'b1);
      send_frame(28'hA5A5A5A, 1'b1, 1'b1);

      // R7: pause beyond the limit drops alignment and holds outputs
      idle(40);
      chk(word_out == last_word, "R7 word held on lost clock", 32'(word_out), 32'(last_word));
      chk(out_clk == 1'b0, "R7 output clock stopped", 32'(out_clk), 32'(0));
      chk(exp_q.size() == 0, "R7 nothing pending on lost clock", 32'(exp_q.size()), 32'(0));
      send_frame(28'h9999999, 1'b0, 1'b1);
      send_frame(28'h6DB6DB6, 1'b1, 1'b1);
      send_frame(WW'($urandom), 1'b1, 1'b1);

      idle(20);
      chk(exp_q.size() == 0, "R5 every expected word delivered", 32'(exp_q.size()), 32'(0));
      chk(word_out == last_word, "R1 final word", 32'(word_out), 32'(last_word));
      report();
   end

endmodule